// File: doc/BRIEF.md
# Host Buffer Test Engine

This block is a self-test function that sits behind a bus endpoint. Software reaches it through a small word-addressed register port. It can load a scratch pattern, program buffer addresses, a transfer length and an interrupt selection, and then start one operation by writing a command word. The engine fetches a buffer from host memory, fills a host buffer with a counting pattern, or copies one host buffer to another, over a simple request/acknowledge memory master port. It can also raise a single interrupt on request.

Each data operation finishes with per-operation success or failure bits in a status word, an XOR checksum of the words it moved, and a one-cycle interrupt pulse. The pulse comes with the interrupt class and vector on side-band outputs. Raise commands exercise the interrupt path alone. A vector that is not legal for the chosen class suppresses the pulse, so the host can probe range handling.

Register map, with byte offsets on `reg_addr`: 0x00 pattern, 0x04 command, 0x08 status, 0x0C source address, 0x10 destination address, 0x14 length in words (16 bits), 0x18 checksum, 0x1C interrupt class (2 bits), 0x20 interrupt vector (12 bits).

Top module: `hostbuf_test_engine`

## Requirements
- R1: The pattern register at offset 0x00 reads back exactly the last 32-bit value written to it.
- R2: After reset every register reads zero. The source, destination, length, checksum, class and vector registers read back what was written, truncated to their widths (length 16, class 2, vector 12 bits). An unmapped offset reads zero. Read data appears on `reg_rdata` one cycle after `reg_re`.
- R3: Command bits are: bit0 raise legacy, bit1 raise MSI, bit2 raise MSI-X, bit3 read host buffer, bit4 write host buffer, bit5 copy. When several bits are set, only the lowest set bit is acted on. A raise command pulses `irq_pulse` with `irq_kind` set by its bit (0, 1, 2) and `irq_vec` equal to the vector register.
- R4: A vector is legal when it is 0 for class 0, 1..32 for class 1, or 1..2048 for class 2. Class 3 is never legal. An illegal selection gives no pulse and leaves status bit6 clear.
- R5: A read fetches `length` words starting at the source address, ascending by 4. It stores their XOR in the checksum register and sets status bit0.
- R6: A write stores `pattern + i` at destination + 4*i for i = 0..length-1. It stores the XOR of those words in the checksum register and sets status bit2.
- R7: A copy moves `length` words from source to destination in ascending order, each word read before it is written. It stores the XOR of the copied words and sets status bit4.
- R8: An address that is zero or not a multiple of 4 is invalid. A bad source sets bit7 and a bad destination sets bit8, together with the fail bit of the operation (bit1 read, bit3 write, bit5 copy). No memory access is made and the checksum register is left unchanged.
- R9: Every data command ends by clearing the command register to zero. With a legal class and vector it also sets status bit6 and gives exactly one single-cycle `irq_pulse`, with `irq_kind` equal to the class register and `irq_vec` equal to the vector register.
- R10: A command written while the command register is non-zero is ignored. The command register holds the running command until it finishes.
- R11: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R12: A data command with length zero succeeds, makes no memory access, and sets the checksum to zero.
- R13: `mem_req` stays high with stable `mem_addr` and `mem_we` until `mem_ack`. Read data is taken from `mem_rdata` in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_re` |
| mem_req | output | 1 | Host memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Host byte address |
| mem_wdata | output | 32 | Host write data |
| mem_ack | input | 1 | Request accepted / read data valid |
| mem_rdata | input | 32 | Host read data |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_kind | output | 2 | Interrupt class: 0 legacy, 1 MSI, 2 MSI-X |
| irq_vec | output | 12 | Interrupt vector |

## Verification
Some properties are checked on every cycle. The interrupt pulse always lasts one cycle and always carries a legal class and vector. A pending memory request holds its address and direction until it is acknowledged. Every issued address is non-zero and word aligned. The command register never changes except to clear while a command runs. The bench scenarios are needed for the data-dependent results: checksums, the contents of host memory after reads, writes and overlapping copies, the status word for each failure mix, the lowest-bit priority, ignored commands and write-one-to-clear, all under a memory that stalls at random.

// File: rtl/htst_pkg.sv
package htst_pkg;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 32;
    localparam int SIZE_W     = 16;
    localparam int VEC_W      = 12;
    localparam int REG_AW     = 6;
    localparam int CMD_W      = 6;
    localparam int STAT_W     = 9;
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int ALIGN_BITS = $clog2(WORD_BYTES);
    localparam int MSI_MAX    = 32;
    localparam int MSIX_MAX   = 2048;

    localparam logic [REG_AW-1:0] OFS_PATTERN = 6'h00;
    localparam logic [REG_AW-1:0] OFS_CMD     = 6'h04;
    localparam logic [REG_AW-1:0] OFS_STATUS  = 6'h08;
    localparam logic [REG_AW-1:0] OFS_SRC     = 6'h0C;
    localparam logic [REG_AW-1:0] OFS_DST     = 6'h10;
    localparam logic [REG_AW-1:0] OFS_SIZE    = 6'h14;
    localparam logic [REG_AW-1:0] OFS_SUM     = 6'h18;
    localparam logic [REG_AW-1:0] OFS_KIND    = 6'h1C;
    localparam logic [REG_AW-1:0] OFS_VEC     = 6'h20;

    localparam logic [STAT_W-1:0] SB_RD_OK   = STAT_W'(1) << 0;
    localparam logic [STAT_W-1:0] SB_RD_FAIL = STAT_W'(1) << 1;
    localparam logic [STAT_W-1:0] SB_WR_OK   = STAT_W'(1) << 2;
    localparam logic [STAT_W-1:0] SB_WR_FAIL = STAT_W'(1) << 3;
    localparam logic [STAT_W-1:0] SB_CP_OK   = STAT_W'(1) << 4;
    localparam logic [STAT_W-1:0] SB_CP_FAIL = STAT_W'(1) << 5;
    localparam logic [STAT_W-1:0] SB_IRQ     = STAT_W'(1) << 6;
    localparam logic [STAT_W-1:0] SB_BAD_SRC = STAT_W'(1) << 7;
    localparam logic [STAT_W-1:0] SB_BAD_DST = STAT_W'(1) << 8;

    typedef enum logic [1:0] {
        IRQ_LEGACY = 2'd0,
        IRQ_MSI    = 2'd1,
        IRQ_MSIX   = 2'd2,
        IRQ_RSVD   = 2'd3
    } irq_kind_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_RAISE_LEG, OP_RAISE_MSI, OP_RAISE_MSIX,
        OP_READ, OP_WRITE, OP_COPY
    } op_e;

    typedef enum logic [1:0] {
        MV_IDLE, MV_FETCH, MV_STORE, MV_FINISH
    } mv_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] pattern;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [SIZE_W-1:0] size;
        irq_kind_e         kind;
        logic [VEC_W-1:0]  vec;
    } cfg_t;

    typedef struct packed {
        logic              done;
        logic              raise;
        irq_kind_e         raise_kind;
        logic [STAT_W-1:0] set_bits;
        logic              sum_valid;
        logic [DATA_W-1:0] sum;
    } result_t;

    function automatic logic addr_ok(input logic [ADDR_W-1:0] a);
        return (a != '0) && (a[ALIGN_BITS-1:0] == '0);
    endfunction

    function automatic op_e decode_cmd(input logic [CMD_W-1:0] c);
        if (c[0])      return OP_RAISE_LEG;
        else if (c[1]) return OP_RAISE_MSI;
        else if (c[2]) return OP_RAISE_MSIX;
        else if (c[3]) return OP_READ;
        else if (c[4]) return OP_WRITE;
        else if (c[5]) return OP_COPY;
        else           return OP_NONE;
    endfunction

    function automatic logic vec_ok(input irq_kind_e k, input logic [VEC_W-1:0] v);
        case (k)
            IRQ_LEGACY: return v == '0;
            IRQ_MSI:    return (v != '0) && (v <= VEC_W'(MSI_MAX));
            IRQ_MSIX:   return (v != '0) && (v <= VEC_W'(MSIX_MAX));
            default:    return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/htst_regs.sv
module htst_regs
    import htst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              done,
    input  logic [STAT_W-1:0] set_bits,
    input  logic              sum_valid,
    input  logic [DATA_W-1:0] sum_in,
    output cfg_t              cfg,
    output logic [CMD_W-1:0]  cmd
);
    cfg_t              cfg_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [STAT_W-1:0] stat_q;
    logic [DATA_W-1:0] sum_q;
    logic [DATA_W-1:0] rdata_q;
    logic [STAT_W-1:0] clr_mask;
    logic [STAT_W-1:0] set_mask;

    assign clr_mask = (reg_we && reg_addr == OFS_STATUS) ? reg_wdata[STAT_W-1:0] : '0;
    assign set_mask = done ? set_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            cmd_q  <= '0;
            stat_q <= '0;
            sum_q  <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_mask) | set_mask;
            if (reg_we) begin
                case (reg_addr)
                    OFS_PATTERN: cfg_q.pattern <= reg_wdata;
                    OFS_CMD:     if (cmd_q == '0) cmd_q <= reg_wdata[CMD_W-1:0];
                    OFS_SRC:     cfg_q.src  <= reg_wdata[ADDR_W-1:0];
                    OFS_DST:     cfg_q.dst  <= reg_wdata[ADDR_W-1:0];
                    OFS_SIZE:    cfg_q.size <= reg_wdata[SIZE_W-1:0];
                    OFS_SUM:     sum_q      <= reg_wdata;
                    OFS_KIND:    cfg_q.kind <= irq_kind_e'(reg_wdata[1:0]);
                    OFS_VEC:     cfg_q.vec  <= reg_wdata[VEC_W-1:0];
                    default: ;
                endcase
            end
            if (done) begin
                cmd_q <= '0;
                if (sum_valid) sum_q <= sum_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (reg_re) begin
            case (reg_addr)
                OFS_PATTERN: rdata_q <= cfg_q.pattern;
                OFS_CMD:     rdata_q <= DATA_W'(cmd_q);
                OFS_STATUS:  rdata_q <= DATA_W'(stat_q);
                OFS_SRC:     rdata_q <= DATA_W'(cfg_q.src);
                OFS_DST:     rdata_q <= DATA_W'(cfg_q.dst);
                OFS_SIZE:    rdata_q <= DATA_W'(cfg_q.size);
                OFS_SUM:     rdata_q <= sum_q;
                OFS_KIND:    rdata_q <= DATA_W'(cfg_q.kind);
                OFS_VEC:     rdata_q <= DATA_W'(cfg_q.vec);
                default:     rdata_q <= '0;
            endcase
        end
    end

    assign reg_rdata = rdata_q;
    assign cfg       = cfg_q;
    assign cmd       = cmd_q;
endmodule

// File: rtl/htst_mover.sv
module htst_mover
    import htst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CMD_W-1:0]  cmd,
    input  cfg_t              cfg,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output result_t           res
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    mv_state_e         st_q;
    op_e               op_q;
    logic [ADDR_W-1:0] rd_ptr_q, wr_ptr_q;
    logic [SIZE_W-1:0] left_q;
    logic [DATA_W-1:0] pat_q, hold_q, sum_q;
    logic [STAT_W-1:0] set_q;
    logic              sumv_q, raise_q;
    irq_kind_e         rkind_q;
    op_e               op_new;
    logic              src_good, dst_good, last_word;

    assign op_new    = decode_cmd(cmd);
    assign src_good  = addr_ok(cfg.src);
    assign dst_good  = addr_ok(cfg.dst);
    assign last_word = (left_q == SIZE_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= MV_IDLE;
            op_q     <= OP_NONE;
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            left_q   <= '0;
            pat_q    <= '0;
            hold_q   <= '0;
            sum_q    <= '0;
            set_q    <= '0;
            sumv_q   <= 1'b0;
            raise_q  <= 1'b0;
            rkind_q  <= IRQ_LEGACY;
        end else begin
            case (st_q)
                MV_IDLE: if (cmd != '0) begin
                    op_q     <= op_new;
                    rd_ptr_q <= cfg.src;
                    wr_ptr_q <= cfg.dst;
                    left_q   <= cfg.size;
                    pat_q    <= cfg.pattern;
                    sum_q    <= '0;
                    set_q    <= '0;
                    sumv_q   <= 1'b0;
                    raise_q  <= 1'b0;
                    st_q     <= MV_FINISH;
                    case (op_new)
                        OP_RAISE_LEG:  begin raise_q <= 1'b1; rkind_q <= IRQ_LEGACY; end
                        OP_RAISE_MSI:  begin raise_q <= 1'b1; rkind_q <= IRQ_MSI;    end
                        OP_RAISE_MSIX: begin raise_q <= 1'b1; rkind_q <= IRQ_MSIX;   end
                        OP_READ: begin
                            if (!src_good) begin
                                set_q <= SB_BAD_SRC | SB_RD_FAIL;
                            end else begin
                                set_q  <= SB_RD_OK;
                                sumv_q <= 1'b1;
                                if (cfg.size != '0) st_q <= MV_FETCH;
                            end
                        end
                        OP_WRITE: begin
                            if (!dst_good) begin
                                set_q <= SB_BAD_DST | SB_WR_FAIL;
                            end else begin
                                set_q  <= SB_WR_OK;
                                sumv_q <= 1'b1;
                                if (cfg.size != '0) st_q <= MV_STORE;
                            end
                        end
                        OP_COPY: begin
                            if (!src_good || !dst_good) begin
                                set_q <= SB_CP_FAIL | (src_good ? '0 : SB_BAD_SRC)
                                                    | (dst_good ? '0 : SB_BAD_DST);
                            end else begin
                                set_q  <= SB_CP_OK;
                                sumv_q <= 1'b1;
                                if (cfg.size != '0) st_q <= MV_FETCH;
                            end
                        end
                        default: ;
                    endcase
                end
                MV_FETCH: if (mem_ack) begin
                    rd_ptr_q <= rd_ptr_q + STEP;
                    if (op_q == OP_COPY) begin
                        hold_q <= mem_rdata;
                        st_q   <= MV_STORE;
                    end else begin
                        sum_q  <= sum_q ^ mem_rdata;
                        left_q <= left_q - SIZE_W'(1);
                        if (last_word) st_q <= MV_FINISH;
                    end
                end
                MV_STORE: if (mem_ack) begin
                    sum_q    <= sum_q ^ mem_wdata;
                    wr_ptr_q <= wr_ptr_q + STEP;
                    pat_q    <= pat_q + DATA_W'(1);
                    left_q   <= left_q - SIZE_W'(1);
                    if (last_word)           st_q <= MV_FINISH;
                    else if (op_q == OP_COPY) st_q <= MV_FETCH;
                end
                default: st_q <= MV_IDLE;
            endcase
        end
    end

    assign mem_req   = (st_q == MV_FETCH) || (st_q == MV_STORE);
    assign mem_we    = (st_q == MV_STORE);
    assign mem_addr  = (st_q == MV_STORE) ? wr_ptr_q : rd_ptr_q;
    assign mem_wdata = (op_q == OP_COPY) ? hold_q : pat_q;

    assign res.done       = (st_q == MV_FINISH);
    assign res.raise      = raise_q;
    assign res.raise_kind = rkind_q;
    assign res.set_bits   = set_q;
    assign res.sum_valid  = sumv_q;
    assign res.sum        = sum_q;
endmodule

// File: rtl/htst_irq.sv
module htst_irq
    import htst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             done,
    input  logic             raise,
    input  irq_kind_e        raise_kind,
    input  irq_kind_e        cfg_kind,
    input  logic [VEC_W-1:0] vec,
    output logic             fire,
    output logic             irq_pulse,
    output irq_kind_e        irq_kind,
    output logic [VEC_W-1:0] irq_vec
);
    irq_kind_e kind_sel;

    assign kind_sel = raise ? raise_kind : cfg_kind;
    assign fire     = done && vec_ok(kind_sel, vec);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pulse <= 1'b0;
            irq_kind  <= IRQ_LEGACY;
            irq_vec   <= '0;
        end else begin
            irq_pulse <= fire;
            if (fire) begin
                irq_kind <= kind_sel;
                irq_vec  <= vec;
            end
        end
    end
endmodule

// File: rtl/hostbuf_test_engine.sv
module hostbuf_test_engine
    import htst_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              irq_pulse,
    output logic [1:0]        irq_kind,
    output logic [VEC_W-1:0]  irq_vec
);
    cfg_t              cfg;
    result_t           res;
    logic [CMD_W-1:0]  cmd_q;
    logic              fire;
    logic [STAT_W-1:0] set_all;
    irq_kind_e         kind_out;

    assign set_all  = res.set_bits | (fire ? SB_IRQ : '0);
    assign irq_kind = kind_out;

    htst_regs u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .done(res.done), .set_bits(set_all),
        .sum_valid(res.sum_valid), .sum_in(res.sum),
        .cfg(cfg), .cmd(cmd_q)
    );

    htst_mover u_mover (
        .clk(clk), .rst(rst), .cmd(cmd_q), .cfg(cfg),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .res(res)
    );

    htst_irq u_irq (
        .clk(clk), .rst(rst), .done(res.done),
        .raise(res.raise), .raise_kind(res.raise_kind),
        .cfg_kind(cfg.kind), .vec(cfg.vec),
        .fire(fire), .irq_pulse(irq_pulse),
        .irq_kind(kind_out), .irq_vec(irq_vec)
    );
endmodule

// File: rtl/htst_checker.sv
module htst_checker (
    input logic        clk,
    input logic        rst,
    input logic        irq_pulse,
    input logic [1:0]  irq_kind,
    input logic [11:0] irq_vec,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic [5:0]  cmd_q
);
    AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> !irq_pulse); // R9

    AST_IRQ_VEC_LEGAL: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> ((irq_kind == 2'd0 && irq_vec == 12'd0) ||
                       (irq_kind == 2'd1 && irq_vec >= 12'd1 && irq_vec <= 12'd32) ||
                       (irq_kind == 2'd2 && irq_vec >= 12'd1 && irq_vec <= 12'd2048))); // R4

    AST_IRQ_CMD_CLEARED: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> (cmd_q == 6'd0)); // R9

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R13

    AST_ADDR_VALID: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr != 32'd0 && mem_addr[1:0] == 2'b00)); // R8

    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (cmd_q != 6'd0)); // R10

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
        (cmd_q != 6'd0) |=> (cmd_q == $past(cmd_q) || cmd_q == 6'd0)); // R10
endmodule

bind hostbuf_test_engine htst_checker u_chk (
    .clk(clk), .rst(rst),
    .irq_pulse(irq_pulse), .irq_kind(irq_kind), .irq_vec(irq_vec),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .cmd_q(cmd_q)
);

// File: tb/sim_hostbuf_test_engine.sv
`timescale 1ns/1ps
module sim_hostbuf_test_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        irq_pulse;
    logic [1:0]  irq_kind;
    logic [11:0] irq_vec;

    int vec_cnt = 0, err_cnt = 0, irq_cnt = 0, acc_cnt = 0;
    logic [1:0]  last_kind;
    logic [11:0] last_vec;
    logic [31:0] host [256];
    logic [31:0] exp_mem [256];
    bit done_flag = 0;

    always #10 clk = ~clk;

    hostbuf_test_engine u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .irq_pulse(irq_pulse), .irq_kind(irq_kind), .irq_vec(irq_vec)
    );

    function automatic logic [31:0] init_word(input int i);
        return 32'hA5C3_0000 ^ (32'(i) * 32'h0001_0203);
    endfunction

    // host memory with random stalls
    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            for (int i = 0; i < 256; i++) host[i] <= init_word(i);
        end else if (mem_req && !mem_ack && ($urandom % 4 != 0)) begin
            mem_ack <= 1'b1;
            acc_cnt = acc_cnt + 1;
            if (mem_we) host[mem_addr[9:2]] <= mem_wdata;
            else        mem_rdata <= host[mem_addr[9:2]];
        end else begin
            mem_ack <= 1'b0;
        end
    end

    always @(posedge clk) begin
        if (!rst && irq_pulse) begin
            irq_cnt = irq_cnt + 1;
            last_kind <= irq_kind;
            last_vec  <= irq_vec;
        end
    end

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        err_cnt++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec_cnt++;
        if (act !== exp) begin
            err_cnt++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        reg_re = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] c;
        for (int k = 0; k < 400; k++) begin
            reg_read(6'h04, c);
            if (c == 0) break;
        end
    endtask

    function automatic logic aok(input logic [31:0] a);
        return a != 0 && a[1:0] == 2'b00;
    endfunction

    function automatic logic vok(input int k, input int n);
        if (k == 0) return n == 0;
        if (k == 1) return n >= 1 && n <= 32;
        if (k == 2) return n >= 1 && n <= 2048;
        return 1'b0;
    endfunction

    task automatic mem_compare(input string tag);
        int bad = 0;
        for (int i = 0; i < 256; i++) if (host[i] !== exp_mem[i]) bad++;
        chk(tag, bad, 0);
    endtask

    // op: 0..2 raise, 3 read, 4 write, 5 copy; extra = higher command bits
    task automatic run_op(input int op, input logic [31:0] src, input logic [31:0] dst,
                          input int size, input int kind, input int num,
                          input logic [31:0] extra, input string tag);
        logic [31:0] pat, sentinel, st, sum, exp_st, exp_sum, w;
        int irq0, acc0, exp_acc, ik;
        logic iok;
        pat = $urandom; sentinel = $urandom;
        reg_write(6'h08, 32'h1FF);
        reg_write(6'h00, pat);
        reg_write(6'h0C, src);
        reg_write(6'h10, dst);
        reg_write(6'h14, 32'(size));
        reg_write(6'h18, sentinel);
        reg_write(6'h1C, 32'(kind));
        reg_write(6'h20, 32'(num));
        irq0 = irq_cnt; acc0 = acc_cnt;
        reg_write(6'h04, (32'd1 << op) | extra);
        wait_idle();
        exp_st = 0; exp_sum = sentinel; exp_acc = 0;
        case (op)
            3: if (!aok(src)) exp_st = 32'h082;
               else begin
                   exp_sum = 0;
                   for (int i = 0; i < size; i++) exp_sum ^= exp_mem[src[9:2] + i];
                   exp_st = 32'h001; exp_acc = size;
               end
            4: if (!aok(dst)) exp_st = 32'h108;
               else begin
                   exp_sum = 0;
                   for (int i = 0; i < size; i++) begin
                       w = pat + 32'(i);
                       exp_mem[dst[9:2] + i] = w;
                       exp_sum ^= w;
                   end
                   exp_st = 32'h004; exp_acc = size;
               end
            5: if (!aok(src) || !aok(dst))
                   exp_st = 32'h020 | (aok(src) ? 0 : 32'h080) | (aok(dst) ? 0 : 32'h100);
               else begin
                   exp_sum = 0;
                   for (int i = 0; i < size; i++) begin
                       w = exp_mem[src[9:2] + i];
                       exp_mem[dst[9:2] + i] = w;
                       exp_sum ^= w;
                   end
                   exp_st = 32'h010; exp_acc = 2 * size;
               end
            default: ;
        endcase
        ik  = (op <= 2) ? op : kind;
        iok = vok(ik, num);
        if (iok) exp_st |= 32'h040;
        reg_read(6'h08, st);  chk({tag, " status"}, st, exp_st);
        reg_read(6'h18, sum); chk({tag, " checksum"}, sum, exp_sum);
        chk(iok ? ((op <= 2) ? "R3 irq count" : "R9 irq count") : "R4 irq suppressed",
            32'(irq_cnt - irq0), iok ? 1 : 0);
        if (iok) begin
            chk("R9 irq kind", 32'(last_kind), 32'(ik));
            chk("R9 irq vec", 32'(last_vec), 32'(num));
        end
        chk({tag, " access count"}, 32'(acc_cnt - acc0), 32'(exp_acc));
        mem_compare({tag, " memory"});
    endtask

    initial begin
        logic [31:0] d, pat;
        int acc0;
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) exp_mem[i] = init_word(i);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        chk("R2 reset irq_pulse", 32'(irq_pulse), 0);
        chk("R2 reset mem_req", 32'(mem_req), 0);
        reg_read(6'h08, d); chk("R2 reset status", d, 0);
        reg_read(6'h04, d); chk("R2 reset command", d, 0);
        reg_read(6'h18, d); chk("R2 reset checksum", d, 0);

        // R1 pattern
        reg_write(6'h00, 32'hDEADBEEF); reg_read(6'h00, d); chk("R1 pattern", d, 32'hDEADBEEF);
        reg_write(6'h00, 32'h0000_0001); reg_read(6'h00, d); chk("R1 pattern", d, 32'h1);

        // R2 readback widths, unmapped
        reg_write(6'h14, 32'hFFFF_FFFF); reg_read(6'h14, d); chk("R2 size width", d, 32'h0000_FFFF);
        reg_write(6'h1C, 32'hFFFF_FFFF); reg_read(6'h1C, d); chk("R2 kind width", d, 32'h3);
        reg_write(6'h20, 32'hFFFF_FFFF); reg_read(6'h20, d); chk("R2 vec width", d, 32'hFFF);
        reg_write(6'h0C, 32'h1234_5678); reg_read(6'h0C, d); chk("R2 src", d, 32'h1234_5678);
        reg_read(6'h24, d); chk("R2 unmapped", d, 0);

        // directed raises (R3, R4)
        run_op(0, 32'h40, 32'h80, 0, 3, 0, 0, "R3 legacy");
        run_op(1, 32'h40, 32'h80, 0, 0, 32, 0, "R3 msi max");
        run_op(2, 32'h40, 32'h80, 0, 0, 2048, 0, "R3 msix max");
        run_op(1, 32'h40, 32'h80, 0, 1, 33, 0, "R4 msi over");
        run_op(2, 32'h40, 32'h80, 0, 2, 0, 0, "R4 msix zero");
        run_op(0, 32'h40, 32'h80, 0, 0, 1, 0, "R4 legacy nonzero");
        // data ops
        run_op(3, 32'h100, 32'h0, 6, 1, 7, 0, "R5 read");
        run_op(4, 32'h0, 32'h200, 5, 2, 100, 0, "R6 write");
        run_op(5, 32'h200, 32'h300, 5, 0, 0, 0, "R7 copy");
        run_op(5, 32'h104, 32'h108, 4, 1, 3, 0, "R13 overlapping copy");
        run_op(4, 32'h0, 32'h200, 3, 3, 1, 0, "R4 class reserved");
        // priority
        run_op(3, 32'h120, 32'h140, 3, 1, 9, 32'h30, "R3 priority");
        // invalid addresses
        run_op(3, 32'h0, 32'h40, 4, 1, 1, 0, "R8 read zero src");
        run_op(4, 32'h40, 32'h102, 4, 1, 1, 0, "R8 write unaligned dst");
        run_op(5, 32'h101, 32'h0, 4, 1, 1, 0, "R8 copy both bad");
        run_op(5, 32'h100, 32'h203, 4, 1, 1, 0, "R8 copy bad dst");
        // zero length
        run_op(3, 32'h100, 32'h0, 0, 1, 2, 0, "R12 read empty");
        run_op(5, 32'h100, 32'h200, 0, 0, 0, 0, "R12 copy empty");

        // R11 write-one-to-clear (status now 0x050 from last copy)
        reg_read(6'h08, d); chk("R11 status before", d, 32'h050);
        reg_write(6'h08, 32'h010); reg_read(6'h08, d); chk("R11 partial clear", d, 32'h040);
        reg_write(6'h08, 32'h000); reg_read(6'h08, d); chk("R11 zero write", d, 32'h040);
        reg_write(6'h08, 32'h040); reg_read(6'h08, d); chk("R11 full clear", d, 0);

        // R10 busy: write started, read command ignored
        pat = 32'h7000_0000;
        reg_write(6'h00, pat);
        reg_write(6'h10, 32'h280);
        reg_write(6'h0C, 32'h040);
        reg_write(6'h14, 8);
        reg_write(6'h1C, 1);
        reg_write(6'h20, 5);
        acc0 = acc_cnt;
        reg_write(6'h04, 32'h10);
        reg_write(6'h04, 32'h08);
        reg_read(6'h04, d); chk("R10 command held", d, 32'h10);
        wait_idle();
        for (int i = 0; i < 8; i++) exp_mem[8'hA0 + i] = pat + 32'(i);
        reg_read(6'h08, d); chk("R10 only write ran", d, 32'h044);
        chk("R10 access count", 32'(acc_cnt - acc0), 8);
        mem_compare("R10 memory");
        reg_read(6'h04, d); chk("R9 command cleared", d, 0);

        // constrained random
        for (int n = 0; n < 60; n++) begin
            int op, sz, kd, nm;
            logic [31:0] s, t;
            op = 3 + ($urandom % 3);
            if ($urandom % 6 == 0) op = $urandom % 3;
            sz = $urandom % 9;
            s = 32'(($urandom % 200) * 4 + 4);
            t = 32'(($urandom % 200) * 4 + 4);
            if ($urandom % 8 == 0) s = ($urandom % 2) ? 32'h0 : (s | 32'h2);
            if ($urandom % 8 == 0) t = ($urandom % 2) ? 32'h0 : (t | 32'h1);
            kd = $urandom % 4;
            case ($urandom % 4)
                0: nm = 0;
                1: nm = 1 + ($urandom % 33);
                2: nm = 1 + ($urandom % 2050);
                default: nm = kd == 1 ? 1 + ($urandom % 32) : (kd == 2 ? 1 + ($urandom % 2048) : 0);
            endcase
            case (op)
                3: run_op(op, s, t, sz, kd, nm, 0, "R5 random read");
                4: run_op(op, s, t, sz, kd, nm, 0, "R6 random write");
                5: run_op(op, s, t, sz, kd, nm, 0, "R7 random copy");
                default: run_op(op, s, t, sz, kd, nm, 0, "R3 random raise");
            endcase
        end

        summary();
        $finish;
    end
endmodule